// File: doc/BRIEF.md
# Paced MIDI Transmit Queue

This block buffers bytes that a host writes for a MIDI output and releases them at a fixed byte rate. Each write to the data register puts one byte into a 16-entry first-in first-out store. A pacing counter, advanced only by a tick enable input, spaces the outgoing bytes exactly 170 ticks apart. Each released byte appears on a one-cycle valid strobe with its data. The serial line encoding of each byte is left to a downstream stage.

A control register has two bits that govern the queue. One holds back transmission. The other masks the transmit-request interrupt. When the last queued byte leaves, the block raises a request flag so that the host can refill the queue. Writing a byte that does not fit drops the oldest queued byte and sets a sticky overflow flag. A status read clears both flags.

The pacing is a three-state machine:
- `ST_EMPTY`: nothing is queued.
- `ST_HELD`: bytes are queued but the hold bit is set.
- `ST_COUNT`: bytes are queued and the counter runs.

The transitions are:
- `ST_EMPTY` to `ST_COUNT`: a data write with the hold bit clear.
- `ST_EMPTY` to `ST_HELD`: a data write with the hold bit set.
- `ST_HELD` to `ST_COUNT`: the hold bit is cleared.
- `ST_COUNT` to `ST_HELD`: the hold bit is set.
- `ST_COUNT` to `ST_EMPTY`: the last byte is released and no write arrives in the same cycle.

Top module: `midi_tx_pacer`

## Requirements
- R1: After reset, `ctrl_q` is 0x0A (bit 3 = transmit hold, bit 1 = receive hold), `fill_level` is 0, `stat_q` is 0, and `tx_valid` and `tx_irq` are low.
- R2: The queue holds up to 16 bytes. It releases them in write order, and `fill_level` shows 0 to 16.
- R3: A data write while 16 bytes are held drops the oldest byte, queues the new byte, and keeps `fill_level` at 16. It also sets the sticky overflow flag, `stat_q` bit 7.
- R4: When a byte is written into an empty queue, the pacing counter is loaded with 169. With the hold bit clear, that byte is released on the 170th tick edge after the write edge. Only cycles with `tick` high count.
- R5: After a byte is released, the counter reloads to 169, so consecutive bytes leave 170 ticks apart. `tx_valid` is high for one cycle per byte, with the byte on `tx_byte`.
- R6: While `ctrl_q` bit 3 is set, no byte is released, and the queued bytes and the counter value are kept.
- R7: When a release leaves the queue empty, the request flag (`stat_q` bit 3) is set.
- R8: A data write clears the request flag. A status read (`stat_rd`) clears both flags. A flag being set in the same cycle as a status read wins over the clear.
- R9: `tx_irq` is high exactly when the request flag is set and `ctrl_q` bits 3 and 2 are both clear.
- R10: A data write into a non-empty queue does not reload the pacing counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Pacing tick enable |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | Write target: 0 = control register, 1 = data register |
| host_wdata | input | 8 | Host write data |
| stat_rd | input | 1 | Status read strobe; clears both flags |
| tx_valid | output | 1 | One-cycle strobe marking a released byte |
| tx_byte | output | 8 | Released byte |
| fill_level | output | 5 | Number of queued bytes, 0 to 16 |
| stat_q | output | 8 | Status: bit 7 = overflow, bit 3 = request, other bits 0 |
| tx_irq | output | 1 | Transmit-request interrupt |
| ctrl_q | output | 8 | Control register value |

## Verification
The bench builds the block with its default parameters: a depth of 16 and a period of 170 ticks. With these values, a full queue drains in under 3000 cycles. This keeps the overflow-then-drain path, the exact 170-tick spacing and the hold/release sequence all within a short run. Random tick gaps, together with random writes, reads and control changes, bring in simultaneous events, such as a write landing on the edge that releases the last byte, or a status read in the same cycle as a flag being set.

// File: rtl/midi_tx_pkg.sv
package midi_tx_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_HELD  = 2'd1,
        ST_COUNT = 2'd2
    } pace_state_e;

    localparam int          CTRL_HOLD_BIT  = 3;
    localparam int          CTRL_MASK_BIT  = 2;
    localparam int          STAT_REQ_BIT   = 3;
    localparam int          STAT_OVF_BIT   = 7;
    localparam logic [7:0]  CTRL_RESET_VAL = 8'h0A;

endpackage

// File: rtl/midi_tx_fifo.sv
module midi_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_nxt,
    output logic          ovf_evt
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_q, wr_q, rd_nxt, wr_nxt;
    logic          full, drop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign drop    = push && full && !pop;
    assign ovf_evt = drop;
    assign rd_nxt  = (pop || drop) ? ptr_inc(rd_q) : rd_q;
    assign wr_nxt  = push ? ptr_inc(wr_q) : wr_q;

    always_comb begin
        if (push && !pop && !full) begin
            cnt_nxt = cnt_q + 1'b1;
        end else if (pop && !push) begin
            cnt_nxt = cnt_q - 1'b1;
        end else begin
            cnt_nxt = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            rd_q  <= rd_nxt;
            wr_q  <= wr_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_q] <= push_data;
        end
    end

    assign head_data = mem[rd_q];

endmodule

// File: rtl/midi_tx_pace_fsm.sv
module midi_tx_pace_fsm
    import midi_tx_pkg::*;
#(
    parameter int PERIOD = 170,
    parameter int DW     = 8,
    parameter int CW     = 5,
    localparam int PW    = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          push,
    input  logic          hold_nxt,
    input  logic [CW-1:0] cnt_nxt,
    input  logic [DW-1:0] head_data,
    output logic          pop,
    output pace_state_e   state_q,
    output logic          tx_valid,
    output logic [DW-1:0] tx_byte
);

    localparam logic [PW-1:0] LOAD_VAL = PW'(PERIOD - 1);

    pace_state_e   state_nxt;
    logic [PW-1:0] pace_q, pace_nxt;

    always_comb begin
        if (cnt_nxt == '0) begin
            state_nxt = ST_EMPTY;
        end else if (hold_nxt) begin
            state_nxt = ST_HELD;
        end else begin
            state_nxt = ST_COUNT;
        end
    end

    assign pop = (state_q == ST_COUNT) && tick && (pace_q == '0);

    always_comb begin
        pace_nxt = pace_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (push) begin
                    pace_nxt = LOAD_VAL;
                end
            end
            ST_HELD: begin
                pace_nxt = pace_q;
            end
            ST_COUNT: begin
                if (tick) begin
                    pace_nxt = pop ? LOAD_VAL : pace_q - 1'b1;
                end
            end
            default: begin
                pace_nxt = pace_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            pace_q  <= '0;
        end else begin
            state_q <= state_nxt;
            pace_q  <= pace_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= pop;
            if (pop) begin
                tx_byte <= head_data;
            end
        end
    end

endmodule

// File: rtl/midi_tx_regs.sv
module midi_tx_regs
    import midi_tx_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic          data_we,
    input  logic [7:0]    wdata,
    input  logic          stat_rd,
    input  logic          pop,
    input  logic [CW-1:0] cnt_q,
    input  logic          ovf_evt,
    output logic [7:0]    ctrl_q,
    output logic [7:0]    ctrl_nxt,
    output logic [7:0]    stat_q,
    output logic          irq
);

    logic req_q, ovf_q, drain;

    assign ctrl_nxt = ctrl_we ? wdata : ctrl_q;
    assign drain    = pop && (cnt_q == CW'(1)) && !data_we;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET_VAL;
            req_q  <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_nxt;
            if (drain) begin
                req_q <= 1'b1;
            end else if (data_we || stat_rd) begin
                req_q <= 1'b0;
            end
            if (ovf_evt) begin
                ovf_q <= 1'b1;
            end else if (stat_rd) begin
                ovf_q <= 1'b0;
            end
        end
    end

    always_comb begin
        stat_q               = '0;
        stat_q[STAT_REQ_BIT] = req_q;
        stat_q[STAT_OVF_BIT] = ovf_q;
    end

    assign irq = req_q && !ctrl_q[CTRL_HOLD_BIT] && !ctrl_q[CTRL_MASK_BIT];

endmodule

// File: rtl/midi_tx_pacer.sv
module midi_tx_pacer
    import midi_tx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int PERIOD = 170,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          host_we,
    input  logic          host_sel,
    input  logic [7:0]    host_wdata,
    input  logic          stat_rd,
    output logic          tx_valid,
    output logic [7:0]    tx_byte,
    output logic [CW-1:0] fill_level,
    output logic [7:0]    stat_q,
    output logic          tx_irq,
    output logic [7:0]    ctrl_q
);

    logic          data_we, ctrl_we, pop, ovf_evt;
    logic [CW-1:0] cnt_nxt;
    logic [7:0]    head_data, ctrl_nxt;
    pace_state_e   pace_state;

    assign data_we = host_we && host_sel;
    assign ctrl_we = host_we && !host_sel;

    midi_tx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (data_we),
        .push_data (host_wdata),
        .pop       (pop),
        .head_data (head_data),
        .cnt_q     (fill_level),
        .cnt_nxt   (cnt_nxt),
        .ovf_evt   (ovf_evt)
    );

    midi_tx_pace_fsm #(.PERIOD(PERIOD), .DW(8), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .push      (data_we),
        .hold_nxt  (ctrl_nxt[CTRL_HOLD_BIT]),
        .cnt_nxt   (cnt_nxt),
        .head_data (head_data),
        .pop       (pop),
        .state_q   (pace_state),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte)
    );

    midi_tx_regs #(.CW(CW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (ctrl_we),
        .data_we  (data_we),
        .wdata    (host_wdata),
        .stat_rd  (stat_rd),
        .pop      (pop),
        .cnt_q    (fill_level),
        .ovf_evt  (ovf_evt),
        .ctrl_q   (ctrl_q),
        .ctrl_nxt (ctrl_nxt),
        .stat_q   (stat_q),
        .irq      (tx_irq)
    );

endmodule

// File: rtl/midi_tx_pacer_chk.sv
module midi_tx_pacer_chk
    import midi_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          data_we,
    input logic          tx_valid,
    input logic [CW-1:0] fill_level,
    input logic [7:0]    stat_q,
    input logic          tx_irq,
    input logic [7:0]    ctrl_q,
    input pace_state_e   state_q
);

    p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CW'(DEPTH));

    p_empty_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) == (fill_level == '0));

    p_keep_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && fill_level == CW'(DEPTH)) |=> (fill_level == CW'(DEPTH)));

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

    p_held_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CTRL_HOLD_BIT] |=> !tx_valid);

    p_drain_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && fill_level == '0) |-> stat_q[STAT_REQ_BIT]);

    p_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        data_we |=> !stat_q[STAT_REQ_BIT]);

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTRL_HOLD_BIT] || ctrl_q[CTRL_MASK_BIT]) |-> !tx_irq);

    p_irq_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> stat_q[STAT_REQ_BIT]);

endmodule

bind midi_tx_pacer midi_tx_pacer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_we    (data_we),
    .tx_valid   (tx_valid),
    .fill_level (fill_level),
    .stat_q     (stat_q),
    .tx_irq     (tx_irq),
    .ctrl_q     (ctrl_q),
    .state_q    (pace_state)
);

// File: tb/midi_tx_pacer_tb.sv
`timescale 1ns/1ps
module midi_tx_pacer_tb_top;

    localparam int DEPTH  = 16;
    localparam int PERIOD = 170;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       host_we = 1'b0;
    logic       host_sel = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       stat_rd = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic [4:0] fill_level;
    logic [7:0] stat_q;
    logic       tx_irq;
    logic [7:0] ctrl_q;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [7:0] mq[$];
    int         mpace = 0;
    logic       mreq = 1'b0;
    logic       movf = 1'b0;
    logic [7:0] mctrl = 8'h0A;
    logic       mvalid = 1'b0;
    logic [7:0] mbyte = 8'h00;

    always #2.5 clk = ~clk;

    midi_tx_pacer #(.DEPTH(DEPTH), .PERIOD(PERIOD)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .host_we(host_we),
        .host_sel(host_sel), .host_wdata(host_wdata), .stat_rd(stat_rd),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .fill_level(fill_level),
        .stat_q(stat_q), .tx_irq(tx_irq), .ctrl_q(ctrl_q)
    );

    function automatic logic [7:0] stat_expect(input logic req, input logic ovf);
        return {ovf, 3'b000, req, 3'b000};
    endfunction

    function automatic logic irq_expect(input logic req, input logic [7:0] ctrl);
        return req && !ctrl[3] && !ctrl[2];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_step(input logic we, input logic sel, input logic [7:0] wd,
                              input logic rd, input logic tk);
        int  n;
        bit  push, active, pop, evt;
        n      = mq.size();
        push   = we && sel;
        active = (n > 0) && !mctrl[3];
        pop    = active && tk && (mpace == 0);
        mvalid = pop;
        if (pop) mbyte = mq[0];
        if (push && n == 0) mpace = PERIOD - 1;
        else if (pop) mpace = PERIOD - 1;
        else if (active && tk) mpace = mpace - 1;
        if (pop) void'(mq.pop_front());
        evt = push && (n == DEPTH) && !pop;
        if (evt) void'(mq.pop_front());
        if (push) mq.push_back(wd);
        if (pop && n == 1 && !push) mreq = 1'b1;
        else if (push || rd) mreq = 1'b0;
        if (evt) movf = 1'b1;
        else if (rd) movf = 1'b0;
        if (we && !sel) mctrl = wd;
    endtask

    task automatic compare_all();
        chk(tx_valid == mvalid, "R5 tx_valid", tx_valid, mvalid);
        if (mvalid) chk(tx_byte == mbyte, "R2 tx_byte order", tx_byte, mbyte);
        chk(fill_level == 5'(mq.size()), "R2 fill_level", fill_level, mq.size());
        chk(stat_q == stat_expect(mreq, movf), "R8 stat_q", stat_q, stat_expect(mreq, movf));
        chk(tx_irq == irq_expect(mreq, mctrl), "R9 tx_irq", tx_irq, irq_expect(mreq, mctrl));
        chk(ctrl_q == mctrl, "R1 ctrl_q", ctrl_q, mctrl);
    endtask

    task automatic cyc(input logic we, input logic sel, input logic [7:0] wd,
                       input logic rd, input logic tk);
        host_we = we; host_sel = sel; host_wdata = wd; stat_rd = rd; tick = tk;
        @(posedge clk);
        model_step(we, sel, wd, rd, tk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input logic tk);
        cyc(1'b0, 1'b0, 8'h00, 1'b0, tk);
    endtask

    task automatic wr_data(input logic [7:0] b);
        cyc(1'b1, 1'b1, b, 1'b0, 1'b1);
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        cyc(1'b1, 1'b0, v, 1'b0, 1'b1);
    endtask

    task automatic wait_valid(output int n);
        n = 0;
        do begin
            idle(1'b1);
            n++;
        end while (!tx_valid && n < 2000);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        int unsigned seed_init;
        seed_init = $urandom(32'd20240223);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(ctrl_q == 8'h0A, "R1 reset ctrl", ctrl_q, 8'h0A);
        chk(fill_level == 0 && stat_q == 0, "R1 reset fill/stat", {fill_level, stat_q}, 0);
        chk(!tx_valid && !tx_irq, "R1 reset valid/irq", {tx_valid, tx_irq}, 0);

        // R6: held while transmit hold bit set
        wr_data(8'h31); wr_data(8'h32); wr_data(8'h33);
        n = 0;
        for (int i = 0; i < 400; i++) begin
            idle(1'b1);
            if (tx_valid) n++;
        end
        chk(n == 0, "R6 no release while held", n, 0);
        chk(fill_level == 3, "R6 contents kept", fill_level, 3);

        // R4/R5: release and exact spacing
        wr_ctrl(8'h00);
        wait_valid(n);
        chk(n == 170, "R4 first byte after 170 ticks", n, 170);
        chk(tx_byte == 8'h31, "R2 first byte", tx_byte, 8'h31);
        wait_valid(n);
        chk(n == 170, "R5 spacing", n, 170);
        chk(tx_byte == 8'h32, "R2 second byte", tx_byte, 8'h32);
        wait_valid(n);
        chk(n == 170, "R5 spacing last", n, 170);
        chk(stat_q[3] == 1'b1, "R7 request on drain", stat_q[3], 1);
        chk(tx_irq == 1'b1, "R9 irq enabled", tx_irq, 1);
        wr_ctrl(8'h04);
        chk(tx_irq == 1'b0, "R9 irq masked", tx_irq, 0);
        wr_ctrl(8'h00);
        chk(tx_irq == 1'b1, "R9 irq unmasked", tx_irq, 1);

        // R8/R10: write clears request, second write does not reload counter
        wr_data(8'hA1);
        chk(stat_q[3] == 1'b0, "R8 write clears request", stat_q[3], 0);
        repeat (49) idle(1'b1);
        wr_data(8'hA2);
        wait_valid(n);
        chk(n == 120, "R10 no reload on non-empty write", n, 120);
        chk(tx_byte == 8'hA1, "R10 byte", tx_byte, 8'hA1);
        wait_valid(n);
        chk(n == 170, "R5 following byte", n, 170);
        cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
        chk(stat_q == 8'h00, "R8 status read clears", stat_q, 0);

        // R3: overflow drops oldest
        wr_ctrl(8'h08);
        for (int i = 0; i < 17; i++) wr_data(8'(8'h10 + i));
        chk(fill_level == 16, "R3 stays full", fill_level, 16);
        chk(stat_q[7] == 1'b1, "R3 overflow flag", stat_q[7], 1);
        wr_ctrl(8'h00);
        wait_valid(n);
        chk(tx_byte == 8'h11, "R3 oldest dropped", tx_byte, 8'h11);
        cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
        chk(stat_q[7] == 1'b0, "R8 overflow cleared", stat_q[7], 0);
        repeat (15 * 170 + 10) idle(1'b1);
        chk(fill_level == 0, "R2 drained", fill_level, 0);

        // random phase
        for (int i = 0; i < 40000; i++) begin
            int unsigned r;
            logic we, sel, rd, tk;
            logic [7:0] wd;
            r   = $urandom_range(0, 999);
            we  = 1'b0; sel = 1'b0; wd = 8'($urandom);
            if (r < 8) begin
                we = 1'b1; sel = 1'b1;
            end else if (r < 9) begin
                we = 1'b1; sel = 1'b0;
                case ($urandom_range(0, 3))
                    0: wd = 8'h00;
                    1: wd = 8'h04;
                    2: wd = 8'h08;
                    default: wd = 8'h0A;
                endcase
            end
            rd = ($urandom_range(0, 299) == 0);
            tk = ($urandom_range(0, 3) != 0);
            cyc(we, sel, wd, rd, tk);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule